// File: doc/BRIEF.md
# Column Significance Neighborhood Window

This block holds the significance and sign state that a bit-plane context coder needs around one column of a four-row stripe. It keeps three adjacent columns in registers: the column one to the left, the column being coded (the centre), and the column one to the right. Each column has six entries: the four stripe samples plus the sample directly above and directly below the stripe. For all four centre samples at once, it presents the horizontal, vertical and diagonal significant-neighbour counts. It also presents the significance and sign of the four side neighbours of each sample, and one flag that says whether the column qualifies for run-length coding.

A shift strobe moves the window one column to the left. The old left column is dropped, and a new right column is taken from the input bus. When a sample of the centre column becomes significant, a write-back port sets it in place, so that samples coded later in the same column see it. Four position inputs mark the code-block edges. Neighbours that lie outside the block read as insignificant with positive sign. The state memories, the context tables and the arithmetic coder all sit outside this block.

Top module: `sigwin_window`

## Requirements
- R1: After reset, every window entry is insignificant with sign 0. All counts and neighbour outputs are then 0, and `rl_ok` is 1.
- R2: On a clock edge with `shift_en` high, the left column takes the centre column and the centre column takes the right column. The right column takes `in_sig`/`in_sgn`, where bit 0 is the row above the stripe, bits 1..4 are the stripe rows from top to bottom, and bit 5 is the row below. Without `shift_en` or `wb_en`, the window holds.
- R3: For stripe row r (0 = top), `h_cnt[2r+1:2r]` is the number of significant samples at row r in the left and right columns (0 to 2).
- R4: `v_cnt[2r+1:2r]` is the number of significant samples directly above and directly below row r in the centre column (0 to 2). This includes the rows outside the stripe.
- R5: `d_cnt[3r+2:3r]` is the number of significant samples at rows r-1 and r+1 of the left and right columns (0 to 4).
- R6: For row r, `nb_sig_h`/`nb_sgn_h` bit 2r is the left neighbour and bit 2r+1 is the right neighbour. For `nb_sig_v`/`nb_sgn_v`, bit 2r is the upper neighbour and bit 2r+1 is the lower neighbour. Each bit is that neighbour's significance or stored sign, after edge masking.
- R7: `rl_ok` is 1 exactly when all four stripe rows have zero horizontal, vertical and diagonal counts.
- R8: `at_left` makes the left column read as all zero, and `at_right` does the same for the right column. `at_top` makes the above-stripe row of all three columns read as zero, and `at_bottom` does the same for the below-stripe row. These masks apply to both significance and sign, and they act combinationally.
- R9: With `wb_en` high and `shift_en` low, centre stripe row `wb_row` becomes significant with sign `wb_sgn` from the next cycle on. No other entry changes.
- R10: With `wb_en` and `shift_en` both high, the write is applied to the centre column before the shift, so it appears in the left column.
- R11: `self_sig`/`self_sgn` bit r is the significance and sign of centre stripe row r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Advance the window by one column |
| in_sig | input | 6 | Significance of the incoming right column |
| in_sgn | input | 6 | Signs of the incoming right column |
| at_left | input | 1 | Centre column is the first column of the block |
| at_right | input | 1 | Centre column is the last column of the block |
| at_top | input | 1 | Stripe is the top stripe of the block |
| at_bottom | input | 1 | Stripe is the bottom stripe of the block |
| wb_en | input | 1 | Mark a centre sample significant |
| wb_row | input | 2 | Stripe row being written back |
| wb_sgn | input | 1 | Sign of the newly significant sample |
| h_cnt | output | 8 | Horizontal significant counts, 2 bits per row |
| v_cnt | output | 8 | Vertical significant counts, 2 bits per row |
| d_cnt | output | 12 | Diagonal significant counts, 3 bits per row |
| nb_sig_h | output | 8 | Left/right neighbour significance per row |
| nb_sgn_h | output | 8 | Left/right neighbour sign per row |
| nb_sig_v | output | 8 | Upper/lower neighbour significance per row |
| nb_sgn_v | output | 8 | Upper/lower neighbour sign per row |
| self_sig | output | 4 | Significance of the centre stripe samples |
| self_sgn | output | 4 | Signs of the centre stripe samples |
| rl_ok | output | 1 | Column qualifies for run-length coding |

## Verification
The bench targets the corners that lie at the edges of the six-row column:

- **Rows outside the stripe.** The top and bottom stripe rows take their vertical and diagonal neighbours from the rows above and below the stripe. An off-by-one in the row slicing would shift those counts into the wrong row.
- **Edge masks.** Each mask is exercised on a column that is full of set bits. A missing or swapped mask then shows up as nonzero counts or signs.
- **Write-back.** The bench confirms that a new significance is visible to its vertical neighbours in the following cycle. It also confirms that a write arriving together with a shift lands in the left column, not in the dropped column or the new centre.
- **Run-length flag.** A column that is significant only within itself must still clear `rl_ok`, because its samples then have vertical neighbours.

// File: rtl/sigwin_pkg.sv
package sigwin_pkg;

  // number of set bits among two neighbour flags
  function automatic logic [1:0] pair_sum(input logic a, input logic b);
    pair_sum = {1'b0, a} + {1'b0, b};
  endfunction

  // number of set bits among four neighbour flags
  function automatic logic [2:0] quad_sum(input logic a, input logic b,
                                          input logic c, input logic d);
    quad_sum = {1'b0, pair_sum(a, b)} + {1'b0, pair_sum(c, d)};
  endfunction

endpackage

// File: rtl/sigwin_regs.sv
module sigwin_regs #(
  parameter int COL_W = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [COL_W-1:0] in_sig,
  input  logic [COL_W-1:0] in_sgn,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic             wb_sgn,
  output logic [COL_W-1:0] l_sig,
  output logic [COL_W-1:0] c_sig,
  output logic [COL_W-1:0] r_sig,
  output logic [COL_W-1:0] l_sgn,
  output logic [COL_W-1:0] c_sgn,
  output logic [COL_W-1:0] r_sgn
);
  // centre column with any write-back applied
  logic [COL_W-1:0] c_sig_upd, c_sgn_upd;

  always_comb begin
    c_sig_upd = c_sig;
    c_sgn_upd = c_sgn;
    if (wb_en) begin
      c_sig_upd[wb_idx] = 1'b1;
      c_sgn_upd[wb_idx] = wb_sgn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_sig <= '0; c_sig <= '0; r_sig <= '0;
      l_sgn <= '0; c_sgn <= '0; r_sgn <= '0;
    end else if (shift_en) begin
      l_sig <= c_sig_upd; l_sgn <= c_sgn_upd;
      c_sig <= r_sig;     c_sgn <= r_sgn;
      r_sig <= in_sig;    r_sgn <= in_sgn;
    end else begin
      c_sig <= c_sig_upd; c_sgn <= c_sgn_upd;
    end
  end
endmodule

// File: rtl/sigwin_mask.sv
module sigwin_mask #(
  parameter int COL_W = 6
) (
  input  logic             at_left,
  input  logic             at_right,
  input  logic             at_top,
  input  logic             at_bottom,
  input  logic [COL_W-1:0] l_sig,
  input  logic [COL_W-1:0] c_sig,
  input  logic [COL_W-1:0] r_sig,
  input  logic [COL_W-1:0] l_sgn,
  input  logic [COL_W-1:0] c_sgn,
  input  logic [COL_W-1:0] r_sgn,
  output logic [COL_W-1:0] ml_sig,
  output logic [COL_W-1:0] mc_sig,
  output logic [COL_W-1:0] mr_sig,
  output logic [COL_W-1:0] ml_sgn,
  output logic [COL_W-1:0] mc_sgn,
  output logic [COL_W-1:0] mr_sgn
);
  // rows that lie inside the block for this stripe
  logic [COL_W-1:0] row_keep;
  assign row_keep = ~{at_bottom, {(COL_W-2){1'b0}}, at_top};

  assign ml_sig = at_left  ? '0 : (l_sig & row_keep);
  assign ml_sgn = at_left  ? '0 : (l_sgn & row_keep);
  assign mr_sig = at_right ? '0 : (r_sig & row_keep);
  assign mr_sgn = at_right ? '0 : (r_sgn & row_keep);
  assign mc_sig = c_sig & row_keep;
  assign mc_sgn = c_sgn & row_keep;
endmodule

// File: rtl/sigwin_row.sv
module sigwin_row
  import sigwin_pkg::*;
(
  // bit 0 row above, bit 1 the sample row, bit 2 row below
  input  logic [2:0] l_sig,
  input  logic [2:0] c_sig,
  input  logic [2:0] r_sig,
  input  logic [2:0] l_sgn,
  input  logic [2:0] c_sgn,
  input  logic [2:0] r_sgn,
  output logic [1:0] h_cnt,
  output logic [1:0] v_cnt,
  output logic [2:0] d_cnt,
  output logic [1:0] hs_sig,
  output logic [1:0] hs_sgn,
  output logic [1:0] vs_sig,
  output logic [1:0] vs_sgn,
  output logic       own_sig,
  output logic       own_sgn,
  output logic       quiet
);
  assign h_cnt   = pair_sum(l_sig[1], r_sig[1]);
  assign v_cnt   = pair_sum(c_sig[0], c_sig[2]);
  assign d_cnt   = quad_sum(l_sig[0], l_sig[2], r_sig[0], r_sig[2]);
  assign hs_sig  = {r_sig[1], l_sig[1]};
  assign hs_sgn  = {r_sgn[1], l_sgn[1]};
  assign vs_sig  = {c_sig[2], c_sig[0]};
  assign vs_sgn  = {c_sgn[2], c_sgn[0]};
  assign own_sig = c_sig[1];
  assign own_sgn = c_sgn[1];
  assign quiet   = (h_cnt == 2'd0) && (v_cnt == 2'd0) && (d_cnt == 3'd0);
endmodule

// File: rtl/sigwin_window.sv
module sigwin_window #(
  parameter  int STRIPE_H = 4,
  localparam int COL_W    = STRIPE_H + 2,
  localparam int ROW_W    = $clog2(STRIPE_H),
  localparam int IDX_W    = $clog2(COL_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic [COL_W-1:0]      in_sig,
  input  logic [COL_W-1:0]      in_sgn,
  input  logic                  at_left,
  input  logic                  at_right,
  input  logic                  at_top,
  input  logic                  at_bottom,
  input  logic                  wb_en,
  input  logic [ROW_W-1:0]      wb_row,
  input  logic                  wb_sgn,
  output logic [2*STRIPE_H-1:0] h_cnt,
  output logic [2*STRIPE_H-1:0] v_cnt,
  output logic [3*STRIPE_H-1:0] d_cnt,
  output logic [2*STRIPE_H-1:0] nb_sig_h,
  output logic [2*STRIPE_H-1:0] nb_sgn_h,
  output logic [2*STRIPE_H-1:0] nb_sig_v,
  output logic [2*STRIPE_H-1:0] nb_sgn_v,
  output logic [STRIPE_H-1:0]   self_sig,
  output logic [STRIPE_H-1:0]   self_sgn,
  output logic                  rl_ok
);
  logic [COL_W-1:0] l_sig, c_sig, r_sig, l_sgn, c_sgn, r_sgn;
  logic [COL_W-1:0] ml_sig, mc_sig, mr_sig, ml_sgn, mc_sgn, mr_sgn;
  logic [IDX_W-1:0] wb_idx;
  logic [STRIPE_H-1:0] row_quiet;

  // stripe row r sits at column entry r+1
  assign wb_idx = IDX_W'(wb_row) + IDX_W'(1);

  sigwin_regs #(.COL_W(COL_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .in_sig(in_sig), .in_sgn(in_sgn),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_sgn(wb_sgn),
    .l_sig(l_sig), .c_sig(c_sig), .r_sig(r_sig),
    .l_sgn(l_sgn), .c_sgn(c_sgn), .r_sgn(r_sgn)
  );

  sigwin_mask #(.COL_W(COL_W)) u_mask (
    .at_left(at_left), .at_right(at_right),
    .at_top(at_top), .at_bottom(at_bottom),
    .l_sig(l_sig), .c_sig(c_sig), .r_sig(r_sig),
    .l_sgn(l_sgn), .c_sgn(c_sgn), .r_sgn(r_sgn),
    .ml_sig(ml_sig), .mc_sig(mc_sig), .mr_sig(mr_sig),
    .ml_sgn(ml_sgn), .mc_sgn(mc_sgn), .mr_sgn(mr_sgn)
  );

  for (genvar r = 0; r < STRIPE_H; r++) begin : g_row
    sigwin_row u_row (
      .l_sig(ml_sig[r+2:r]), .c_sig(mc_sig[r+2:r]), .r_sig(mr_sig[r+2:r]),
      .l_sgn(ml_sgn[r+2:r]), .c_sgn(mc_sgn[r+2:r]), .r_sgn(mr_sgn[r+2:r]),
      .h_cnt(h_cnt[2*r+1:2*r]), .v_cnt(v_cnt[2*r+1:2*r]),
      .d_cnt(d_cnt[3*r+2:3*r]),
      .hs_sig(nb_sig_h[2*r+1:2*r]), .hs_sgn(nb_sgn_h[2*r+1:2*r]),
      .vs_sig(nb_sig_v[2*r+1:2*r]), .vs_sgn(nb_sgn_v[2*r+1:2*r]),
      .own_sig(self_sig[r]), .own_sgn(self_sgn[r]),
      .quiet(row_quiet[r])
    );
  end

  assign rl_ok = &row_quiet;
endmodule

// File: rtl/sigwin_checker.sv
module sigwin_checker #(
  parameter int STRIPE_H = 4,
  parameter int COL_W    = 6,
  parameter int ROW_W    = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  shift_en,
  input logic [COL_W-1:0]      in_sig,
  input logic                  wb_en,
  input logic [ROW_W-1:0]      wb_row,
  input logic                  at_left,
  input logic                  at_right,
  input logic                  at_top,
  input logic                  at_bottom,
  input logic [COL_W-1:0]      win_l,
  input logic [COL_W-1:0]      win_c,
  input logic [COL_W-1:0]      win_r,
  input logic [2*STRIPE_H-1:0] h_cnt,
  input logic [2*STRIPE_H-1:0] v_cnt,
  input logic [2*STRIPE_H-1:0] nb_sig_h,
  input logic [2*STRIPE_H-1:0] nb_sgn_h,
  input logic [2*STRIPE_H-1:0] nb_sig_v,
  input logic [STRIPE_H-1:0]   self_sig,
  input logic                  rl_ok
);
  p_shift_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !wb_en) |=> (win_l == $past(win_c)));

  p_shift_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (win_r == $past(in_sig)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !wb_en) |=> ($stable(win_l) && $stable(win_c) && $stable(win_r)));

  p_rl_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rl_ok |-> (nb_sig_h == '0 && nb_sig_v == '0));

  p_wb_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !shift_en) |=> self_sig[$past(wb_row)]);

  p_wb_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && shift_en) |=> win_l[int'($past(wb_row)) + 1]);

  p_top_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |-> !nb_sig_v[0]);

  p_bottom_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    at_bottom |-> !nb_sig_v[2*STRIPE_H-1]);

  for (genvar r = 0; r < STRIPE_H; r++) begin : g_rchk
    p_left_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      at_left |-> (!nb_sig_h[2*r] && !nb_sgn_h[2*r]));
    p_right_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      at_right |-> (!nb_sig_h[2*r+1] && !nb_sgn_h[2*r+1]));
    p_h_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      h_cnt[2*r+1:2*r] <= 2'd2);
    p_v_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      v_cnt[2*r+1:2*r] <= 2'd2);
  end
endmodule

bind sigwin_window sigwin_checker #(
  .STRIPE_H(STRIPE_H), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .in_sig(in_sig),
  .wb_en(wb_en), .wb_row(wb_row),
  .at_left(at_left), .at_right(at_right), .at_top(at_top), .at_bottom(at_bottom),
  .win_l(l_sig), .win_c(c_sig), .win_r(r_sig),
  .h_cnt(h_cnt), .v_cnt(v_cnt),
  .nb_sig_h(nb_sig_h), .nb_sgn_h(nb_sgn_h), .nb_sig_v(nb_sig_v),
  .self_sig(self_sig), .rl_ok(rl_ok)
);

// File: tb/sigwin_window_test.sv
module sigwin_window_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0;
  logic [5:0] in_sig = '0, in_sgn = '0;
  logic at_left = 1'b0, at_right = 1'b0, at_top = 1'b0, at_bottom = 1'b0;
  logic wb_en = 1'b0;
  logic [1:0] wb_row = '0;
  logic wb_sgn = 1'b0;
  logic [7:0] h_cnt, v_cnt, nb_sig_h, nb_sgn_h, nb_sig_v, nb_sgn_v;
  logic [11:0] d_cnt;
  logic [3:0] self_sig, self_sgn;
  logic rl_ok;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sigwin_window uut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .in_sig(in_sig), .in_sgn(in_sgn),
    .at_left(at_left), .at_right(at_right), .at_top(at_top), .at_bottom(at_bottom),
    .wb_en(wb_en), .wb_row(wb_row), .wb_sgn(wb_sgn),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .d_cnt(d_cnt),
    .nb_sig_h(nb_sig_h), .nb_sgn_h(nb_sgn_h),
    .nb_sig_v(nb_sig_v), .nb_sgn_v(nb_sgn_v),
    .self_sig(self_sig), .self_sgn(self_sgn), .rl_ok(rl_ok)
  );

  // {left sig, centre sig, right sig, left sgn, centre sgn, right sgn, edges}
  // each column: bit0 above stripe, bits1..4 stripe rows, bit5 below
  // edges: {at_left, at_right, at_top, at_bottom}
  localparam logic [39:0] VEC [9] = '{
    {6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000000, 4'b0000},
    {6'b111111, 6'b000000, 6'b000000, 6'b111111, 6'b000000, 6'b000000, 4'b0000},
    {6'b111111, 6'b000000, 6'b000000, 6'b111111, 6'b000000, 6'b000000, 4'b1000},
    {6'b000000, 6'b100001, 6'b000000, 6'b000000, 6'b100001, 6'b000000, 4'b0000},
    {6'b000000, 6'b100001, 6'b000000, 6'b000000, 6'b100001, 6'b000000, 4'b0011},
    {6'b101010, 6'b001100, 6'b010101, 6'b110011, 6'b011000, 6'b100110, 4'b0000},
    {6'b101010, 6'b001100, 6'b010101, 6'b110011, 6'b011000, 6'b100110, 4'b0100},
    {6'b000000, 6'b011110, 6'b000000, 6'b000000, 6'b010010, 6'b000000, 4'b0000},
    {6'b000001, 6'b000000, 6'b100000, 6'b000001, 6'b000000, 6'b100000, 4'b0000}
  };

  logic [7:0]  e_h, e_v, e_hs, e_hn, e_vs, e_vn;
  logic [11:0] e_d;
  logic [3:0]  e_ss, e_sn;
  logic        e_rl;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent reference: padded grid, neighbours by coordinates
  task automatic model(input logic [5:0] ls, cs, rs, lg, cg, rg, input logic [3:0] ed);
    logic gs [3][6];
    logic gn [3][6];
    for (int k = 0; k < 6; k++) begin
      gs[0][k] = ls[k]; gs[1][k] = cs[k]; gs[2][k] = rs[k];
      gn[0][k] = lg[k]; gn[1][k] = cg[k]; gn[2][k] = rg[k];
    end
    for (int col = 0; col < 3; col++) begin
      for (int k = 0; k < 6; k++) begin
        if ((col == 0 && ed[3]) || (col == 2 && ed[2]) || (k == 0 && ed[1]) || (k == 5 && ed[0])) begin
          gs[col][k] = 1'b0; gn[col][k] = 1'b0;
        end
      end
    end
    e_rl = 1'b1;
    for (int r = 0; r < 4; r++) begin
      int k;
      int hh, vv, dd;
      k = r + 1;
      hh = int'(gs[0][k]) + int'(gs[2][k]);
      vv = int'(gs[1][k-1]) + int'(gs[1][k+1]);
      dd = int'(gs[0][k-1]) + int'(gs[0][k+1]) + int'(gs[2][k-1]) + int'(gs[2][k+1]);
      e_h[2*r +: 2] = 2'(hh);
      e_v[2*r +: 2] = 2'(vv);
      e_d[3*r +: 3] = 3'(dd);
      e_hs[2*r] = gs[0][k]; e_hs[2*r+1] = gs[2][k];
      e_hn[2*r] = gn[0][k]; e_hn[2*r+1] = gn[2][k];
      e_vs[2*r] = gs[1][k-1]; e_vs[2*r+1] = gs[1][k+1];
      e_vn[2*r] = gn[1][k-1]; e_vn[2*r+1] = gn[1][k+1];
      e_ss[r] = gs[1][k]; e_sn[r] = gn[1][k];
      if (hh + vv + dd != 0) e_rl = 1'b0;
    end
  endtask

  task automatic push(input logic [5:0] s, input logic [5:0] g);
    in_sig = s; in_sgn = g; shift_en = 1'b1;
    @(posedge clk); #1;
    shift_en = 1'b0; in_sig = '0; in_sgn = '0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 h_cnt", 32'(h_cnt), 0);
    chk("R1 nb_sig_h", 32'(nb_sig_h), 0);
    chk("R1 self_sig", 32'(self_sig), 0);
    chk("R1 rl_ok", 32'(rl_ok), 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // table walk: R2 loading order, R3-R8, R11
    for (int i = 0; i < 9; i++) begin
      logic [39:0] v;
      v = VEC[i];
      push(v[39:34], v[21:16]);
      push(v[33:28], v[15:10]);
      push(v[27:22], v[9:4]);
      {at_left, at_right, at_top, at_bottom} = v[3:0];
      #1;
      model(v[39:34], v[33:28], v[27:22], v[21:16], v[15:10], v[9:4], v[3:0]);
      chk("R3 h_cnt", 32'(h_cnt), 32'(e_h));
      chk("R4 v_cnt", 32'(v_cnt), 32'(e_v));
      chk("R5 d_cnt", 32'(d_cnt), 32'(e_d));
      chk("R6 nb_sig_h", 32'(nb_sig_h), 32'(e_hs));
      chk("R6 nb_sgn_h", 32'(nb_sgn_h), 32'(e_hn));
      chk("R6 nb_sig_v", 32'(nb_sig_v), 32'(e_vs));
      chk("R8 nb_sgn_v", 32'(nb_sgn_v), 32'(e_vn));
      chk("R11 self_sig", 32'(self_sig), 32'(e_ss));
      chk("R11 self_sgn", 32'(self_sgn), 32'(e_sn));
      chk("R7 rl_ok", 32'(rl_ok), 32'(e_rl));
      {at_left, at_right, at_top, at_bottom} = 4'b0000;
    end

    // R9: write-back into a clear window
    push('0, '0); push('0, '0); push('0, '0);
    wb_en = 1'b1; wb_row = 2'd2; wb_sgn = 1'b1;
    @(posedge clk); #1;
    wb_en = 1'b0;
    chk("R9 self_sig", 32'(self_sig), 32'h4);
    chk("R9 self_sgn", 32'(self_sgn), 32'h4);
    chk("R9 v_cnt", 32'(v_cnt), 32'h44);
    chk("R9 nb_sig_h", 32'(nb_sig_h), 0);
    chk("R9 rl_ok", 32'(rl_ok), 0);

    // R10: write-back with shift lands in the left column
    wb_en = 1'b1; wb_row = 2'd0; wb_sgn = 1'b0; shift_en = 1'b1;
    @(posedge clk); #1;
    wb_en = 1'b0; shift_en = 1'b0;
    chk("R10 nb_sig_h", 32'(nb_sig_h), 32'h11);
    chk("R10 nb_sgn_h", 32'(nb_sgn_h), 32'h10);
    chk("R10 self_sig", 32'(self_sig), 0);

    // R2: idle cycles hold the window
    repeat (2) @(posedge clk);
    #1;
    chk("R2 hold nb_sig_h", 32'(nb_sig_h), 32'h11);

    // R2: next shift discards the old left column
    push('0, '0);
    chk("R2 discard nb_sig_h", 32'(nb_sig_h), 0);
    chk("R2 discard rl_ok", 32'(rl_ok), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule